// File: doc/BRIEF.md
# Deferred Group Fault Arbiter

This block gathers high-group fault requests that arrive at arbitrary times from around the processor, such as connect, timer runout and execute, together with three floating trap requests whose use depends on a compatibility mode. A request never reaches the arbiter directly. It first sets a bit in a staging register, and it moves into the pending register only when the fault sequencer gives an advance strobe. This keeps the set of eligible faults frozen between advance points, however requests arrive.

When the sequencer gives a dispatch strobe, the block picks one pending fault by a fixed priority and clears its bit. One cycle later it presents the fault number, a 64-bit subcode and a flag marking floating traps. For ordinary faults the subcode is the one recorded with the most recent request for that number. If nothing is eligible, the block reports a trouble fault, and its subcode carries the pending mask so that the sequencer can see what was left over. Two status outputs tell the sequencer whether anything is pending, one of them leaving timer runout out. A separate clear input withdraws a timer-runout fault that is no longer wanted.

Top module: `gfa_arbiter`

## Requirements
- R1: After reset, fault_valid, pend_any and pend_no_timer are 0 and no fault is staged or pending.
- R2: A set request with req_set=1 sets bit req_num in staging and records req_sub for that number, and a later request for the same number replaces the recorded value. A staged bit does not affect pend_any or dispatch until it is promoted.
- R3: An advance strobe ORs staging into pending and empties staging. A set request in the same cycle as an advance stays staged and is promoted at the following advance.
- R4: A floating trap request with ftrap_code c sets floating staging bit (c>>1)-1. Codes with c>>1 equal to 0 (codes 0 and 1) are ignored, and bit 0 of the code has no other effect. Floating staging is promoted by advance only while compat_mode=1, and otherwise it stays staged.
- R5: Dispatch priority is connect (bit 8) first, then timer runout (bit 4) only while allow_timer=1, then execute (bit 15). Each is reported with its own number and recorded subcode and fault_float=0.
- R6: When compat_mode=1 and none of R5 applies, the lowest set floating pending bit i (0..2) is dispatched as fault_num=i+1 with fault_float=1 and fault_sub=0.
- R7: The dispatched bit is cleared from its pending register, and all other pending bits are kept.
- R8: When nothing is eligible, dispatch reports fault_num=31 with fault_float=0, and fault_sub is the 32-bit pending mask zero-extended. No pending bit is cleared.
- R9: pend_any is 1 when any pending bit is set, or when compat_mode=1 and any floating pending bit is set.
- R10: pend_no_timer is like pend_any but does not count pending bit 4.
- R11: A timer_clr pulse removes only pending bit 4.
- R12: fault_valid is 1 exactly in the cycle after a dispatch strobe. fault_num, fault_sub and fault_float keep their values until the next dispatch.
- R13: Within one cycle, dispatch and timer_clr act on the pending bits held before that cycle's promotion, so bits promoted in the same cycle survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_set | input | 1 | Fault set request |
| req_num | input | 5 | Fault number of the request |
| req_sub | input | 64 | Subcode recorded with the request |
| ftrap_set | input | 1 | Floating trap request |
| ftrap_code | input | 3 | Floating trap code |
| compat_mode | input | 1 | Enables the floating trap tier |
| advance | input | 1 | Promote staging to pending |
| timer_clr | input | 1 | Remove the timer-runout pending bit |
| dispatch | input | 1 | Select and retire one fault |
| allow_timer | input | 1 | Timer runout is eligible for dispatch |
| fault_valid | output | 1 | Dispatch result valid |
| fault_num | output | 5 | Dispatched fault number |
| fault_sub | output | 64 | Dispatched subcode |
| fault_float | output | 1 | Dispatched fault is a floating trap |
| pend_any | output | 1 | Any fault pending |
| pend_no_timer | output | 1 | Any fault pending other than timer runout |

## Verification
The main sweep goes through every subset of four pending faults (one that cannot be dispatched, timer runout, connect and execute), every floating mask, and both values of allow_timer and compat_mode. Each case is then drained by repeated dispatch. This separates the priority order, the conditional timer skip, the floating tier and the trouble fallback whose subcode exposes what is left. A floating mask staged while compat_mode is low is later enabled, which tells holding in staging apart from dropping the request. Directed sequences cover the same-cycle cases: a set with an advance, a dispatch with an advance, and a timer clear with an advance. They also cover replacement of the recorded subcode and the ignored floating codes.

// File: rtl/gfa_pkg.sv
package gfa_pkg;
  typedef enum logic [2:0] {
    PICK_CONN,
    PICK_TIMER,
    PICK_EXEC,
    PICK_FLOAT,
    PICK_TROUBLE
  } pick_e;
endpackage

// File: rtl/gfa_stage_pend.sv
module gfa_stage_pend #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic         promote,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] stage_q,
  output logic [W-1:0] pend_q
);
  logic [W-1:0] stage_d, pend_d;
  logic         stage_en, pend_en;

  always_comb begin
    stage_en = promote | (|set_mask);
    pend_en  = promote | (|clr_mask);
    stage_d  = promote ? set_mask : (stage_q | set_mask);
    pend_d   = (pend_q & ~clr_mask) | (promote ? stage_q : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      pend_q  <= '0;
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (pend_en)  pend_q  <= pend_d;
    end
  end
endmodule

// File: rtl/gfa_subcode_store.sv
module gfa_subcode_store #(
  parameter int N     = 32,
  parameter int SUB_W = 64,
  localparam int IW   = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [SUB_W-1:0] wr_data,
  input  logic [IW-1:0]    rd_idx,
  output logic [SUB_W-1:0] rd_data
);
  logic [SUB_W-1:0] slot_q [N];

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[i] <= '0;
      else if (slot_en) slot_q[i] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/gfa_pick.sv
module gfa_pick
  import gfa_pkg::*;
#(
  parameter int N         = 32,
  parameter int FLOAT_N   = 3,
  parameter int CONN_BIT  = 8,
  parameter int TIMER_BIT = 4,
  parameter int EXEC_BIT  = 15,
  localparam int IW       = $clog2(N)
) (
  input  logic [N-1:0]       pend,
  input  logic [FLOAT_N-1:0] fpend,
  input  logic               compat,
  input  logic               allow_timer,
  output pick_e              pick,
  output logic [IW-1:0]      pick_num,
  output logic               pick_float,
  output logic [N-1:0]       clr_mask,
  output logic [FLOAT_N-1:0] fclr_mask
);
  always_comb begin
    pick       = PICK_TROUBLE;
    pick_num   = IW'(N - 1);
    pick_float = 1'b0;
    clr_mask   = '0;
    fclr_mask  = '0;
    if (pend[CONN_BIT]) begin
      pick               = PICK_CONN;
      pick_num           = IW'(CONN_BIT);
      clr_mask[CONN_BIT] = 1'b1;
    end else if (allow_timer && pend[TIMER_BIT]) begin
      pick                = PICK_TIMER;
      pick_num            = IW'(TIMER_BIT);
      clr_mask[TIMER_BIT] = 1'b1;
    end else if (pend[EXEC_BIT]) begin
      pick               = PICK_EXEC;
      pick_num           = IW'(EXEC_BIT);
      clr_mask[EXEC_BIT] = 1'b1;
    end else if (compat && (|fpend)) begin
      pick       = PICK_FLOAT;
      pick_float = 1'b1;
      for (int i = FLOAT_N - 1; i >= 0; i--) begin
        if (fpend[i]) begin
          pick_num  = IW'(i + 1);
          fclr_mask = FLOAT_N'(1) << i;
        end
      end
    end
  end
endmodule

// File: rtl/gfa_arbiter.sv
module gfa_arbiter
  import gfa_pkg::*;
#(
  parameter int NUM_FAULTS = 32,
  parameter int SUB_W      = 64,
  parameter int FLOAT_N    = 3,
  parameter int CONN_BIT   = 8,
  parameter int TIMER_BIT  = 4,
  parameter int EXEC_BIT   = 15,
  localparam int NUM_W     = $clog2(NUM_FAULTS),
  localparam int FCODE_W   = $clog2(2 * FLOAT_N + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_set,
  input  logic [NUM_W-1:0]   req_num,
  input  logic [SUB_W-1:0]   req_sub,
  input  logic               ftrap_set,
  input  logic [FCODE_W-1:0] ftrap_code,
  input  logic               compat_mode,
  input  logic               advance,
  input  logic               timer_clr,
  input  logic               dispatch,
  input  logic               allow_timer,
  output logic               fault_valid,
  output logic [NUM_W-1:0]   fault_num,
  output logic [SUB_W-1:0]   fault_sub,
  output logic               fault_float,
  output logic               pend_any,
  output logic               pend_no_timer
);
  localparam logic [NUM_FAULTS-1:0] TIMER_MASK = NUM_FAULTS'(1) << TIMER_BIT;

  logic [NUM_FAULTS-1:0] main_set, main_clr, main_stage, main_pend;
  logic [FLOAT_N-1:0]    flt_set, flt_clr, flt_stage, flt_pend;
  logic [FCODE_W-2:0]    flt_idx;
  logic                  flt_promote;

  pick_e                 pick;
  logic [NUM_W-1:0]      pick_num;
  logic                  pick_float;
  logic [NUM_FAULTS-1:0] pick_clr;
  logic [FLOAT_N-1:0]    pick_fclr;
  logic [SUB_W-1:0]      store_rd;
  logic [SUB_W-1:0]      sub_d;

  logic                  valid_q;
  logic [NUM_W-1:0]      num_q;
  logic [SUB_W-1:0]      sub_q;
  logic                  float_q;

  // request decode
  always_comb begin
    main_set = req_set ? (NUM_FAULTS'(1) << req_num) : '0;
    flt_idx  = ftrap_code[FCODE_W-1:1];
    flt_set  = '0;
    if (ftrap_set && (flt_idx != '0) && (int'(flt_idx) <= FLOAT_N))
      flt_set = FLOAT_N'(1) << (flt_idx - 1'b1);
    flt_promote = advance & compat_mode;
    main_clr = (dispatch ? pick_clr : '0) | (timer_clr ? TIMER_MASK : '0);
    flt_clr  = dispatch ? pick_fclr : '0;
  end

  gfa_stage_pend #(.W(NUM_FAULTS)) u_main (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (main_set),
    .promote  (advance),
    .clr_mask (main_clr),
    .stage_q  (main_stage),
    .pend_q   (main_pend)
  );

  gfa_stage_pend #(.W(FLOAT_N)) u_float (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (flt_set),
    .promote  (flt_promote),
    .clr_mask (flt_clr),
    .stage_q  (flt_stage),
    .pend_q   (flt_pend)
  );

  gfa_subcode_store #(.N(NUM_FAULTS), .SUB_W(SUB_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (req_set),
    .wr_idx  (req_num),
    .wr_data (req_sub),
    .rd_idx  (pick_num),
    .rd_data (store_rd)
  );

  gfa_pick #(
    .N         (NUM_FAULTS),
    .FLOAT_N   (FLOAT_N),
    .CONN_BIT  (CONN_BIT),
    .TIMER_BIT (TIMER_BIT),
    .EXEC_BIT  (EXEC_BIT)
  ) u_pick (
    .pend        (main_pend),
    .fpend       (flt_pend),
    .compat      (compat_mode),
    .allow_timer (allow_timer),
    .pick        (pick),
    .pick_num    (pick_num),
    .pick_float  (pick_float),
    .clr_mask    (pick_clr),
    .fclr_mask   (pick_fclr)
  );

  always_comb begin
    case (pick)
      PICK_FLOAT:   sub_d = '0;
      PICK_TROUBLE: sub_d = SUB_W'(main_pend);
      default:      sub_d = store_rd;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      num_q   <= '0;
      sub_q   <= '0;
      float_q <= 1'b0;
    end else begin
      valid_q <= dispatch;
      if (dispatch) begin
        num_q   <= pick_num;
        sub_q   <= sub_d;
        float_q <= pick_float;
      end
    end
  end

  assign fault_valid   = valid_q;
  assign fault_num     = num_q;
  assign fault_sub     = sub_q;
  assign fault_float   = float_q;
  assign pend_any      = (|main_pend) | (compat_mode & (|flt_pend));
  assign pend_no_timer = (|(main_pend & ~TIMER_MASK)) | (compat_mode & (|flt_pend));
endmodule

// File: rtl/gfa_checker.sv
module gfa_checker #(
  parameter int NUM_FAULTS = 32,
  parameter int SUB_W      = 64,
  parameter int FLOAT_N    = 3,
  parameter int CONN_BIT   = 8,
  parameter int TIMER_BIT  = 4,
  localparam int NUM_W     = $clog2(NUM_FAULTS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_set,
  input logic                  advance,
  input logic                  timer_clr,
  input logic                  dispatch,
  input logic                  compat_mode,
  input logic [NUM_FAULTS-1:0] stg,
  input logic [NUM_FAULTS-1:0] pend,
  input logic [FLOAT_N-1:0]    fpend,
  input logic                  fault_valid,
  input logic [NUM_W-1:0]      fault_num,
  input logic [SUB_W-1:0]      fault_sub,
  input logic                  fault_float
);
  AST_VALID_AFTER_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |=> fault_valid); // R12
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !dispatch |=> !fault_valid); // R12
  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !req_set) |=> $stable(stg)); // R2
  AST_CONN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch && pend[CONN_BIT]) |=> (fault_num == NUM_W'(CONN_BIT) && !fault_float)); // R5
  AST_DISPATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch && pend[CONN_BIT] && !(advance && stg[CONN_BIT])) |=> !pend[CONN_BIT]); // R7
  AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_clr && !(advance && stg[TIMER_BIT])) |=> !pend[TIMER_BIT]); // R11
  AST_FLOAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_float) |-> (fault_num >= NUM_W'(1) && fault_num <= NUM_W'(FLOAT_N) && fault_sub == '0)); // R6
  AST_TROUBLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch && pend == '0 && !(compat_mode && (|fpend))) |=> (fault_num == NUM_W'(NUM_FAULTS - 1) && fault_sub == '0 && !fault_float)); // R8
endmodule

bind gfa_arbiter gfa_checker #(
  .NUM_FAULTS (NUM_FAULTS),
  .SUB_W      (SUB_W),
  .FLOAT_N    (FLOAT_N),
  .CONN_BIT   (CONN_BIT),
  .TIMER_BIT  (TIMER_BIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_set     (req_set),
  .advance     (advance),
  .timer_clr   (timer_clr),
  .dispatch    (dispatch),
  .compat_mode (compat_mode),
  .stg         (main_stage),
  .pend        (main_pend),
  .fpend       (flt_pend),
  .fault_valid (fault_valid),
  .fault_num   (fault_num),
  .fault_sub   (fault_sub),
  .fault_float (fault_float)
);

// File: tb/tb_gfa_arbiter.sv
module tb_gfa_arbiter;
  logic        clk, rst_n;
  logic        req_set, ftrap_set, compat_mode, advance, timer_clr, dispatch, allow_timer;
  logic [4:0]  req_num;
  logic [63:0] req_sub;
  logic [2:0]  ftrap_code;
  logic        fault_valid, fault_float, pend_any, pend_no_timer;
  logic [4:0]  fault_num;
  logic [63:0] fault_sub;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_pend;
  logic [2:0]  m_fpend, m_fstage;
  logic [63:0] m_sub [32];

  gfa_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_num(req_num), .req_sub(req_sub),
    .ftrap_set(ftrap_set), .ftrap_code(ftrap_code), .compat_mode(compat_mode),
    .advance(advance), .timer_clr(timer_clr), .dispatch(dispatch), .allow_timer(allow_timer),
    .fault_valid(fault_valid), .fault_num(fault_num), .fault_sub(fault_sub),
    .fault_float(fault_float), .pend_any(pend_any), .pend_no_timer(pend_no_timer)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {req_set, ftrap_set, advance, timer_clr, dispatch} = '0;
    req_num = '0; req_sub = '0; ftrap_code = '0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
    m_pend = '0; m_fpend = '0; m_fstage = '0;
    for (int i = 0; i < 32; i++) m_sub[i] = '0;
  endtask

  task automatic set_req(int n, logic [63:0] sub);
    req_set = 1'b1; req_num = 5'(n); req_sub = sub;
    tick();
    req_set = 1'b0;
    m_sub[n] = sub;
  endtask

  task automatic set_float(int code);
    ftrap_set = 1'b1; ftrap_code = 3'(code);
    tick();
    ftrap_set = 1'b0;
  endtask

  task automatic pulse_adv();
    advance = 1'b1;
    tick();
    advance = 1'b0;
  endtask

  task automatic disp_expect(string req, logic [4:0] en, logic [63:0] es, logic ef);
    dispatch = 1'b1;
    tick();
    dispatch = 1'b0;
    chk({req, " valid"}, 64'(fault_valid), 64'd1);
    chk({req, " num"}, 64'(fault_num), 64'(en));
    chk({req, " sub"}, fault_sub, es);
    chk({req, " float"}, 64'(fault_float), 64'(ef));
    tick();
    chk("R12 valid drop", 64'(fault_valid), 64'd0);
    chk("R12 num hold", 64'(fault_num), 64'(en));
  endtask

  // one dispatch against the bench model; returns 1 when trouble was reported
  task automatic disp_model(output bit trouble);
    logic [4:0] en; logic [63:0] es; logic ef; string tag;
    trouble = 1'b0; ef = 1'b0;
    if (m_pend[8]) begin
      en = 5'd8; es = m_sub[8]; tag = "R5 conn"; m_pend[8] = 1'b0;
    end else if (allow_timer && m_pend[4]) begin
      en = 5'd4; es = m_sub[4]; tag = "R5 timer"; m_pend[4] = 1'b0;
    end else if (m_pend[15]) begin
      en = 5'd15; es = m_sub[15]; tag = "R5 exec"; m_pend[15] = 1'b0;
    end else if (compat_mode && m_fpend != 0) begin
      ef = 1'b1; es = '0; tag = "R6 float";
      if (m_fpend[0])      begin en = 5'd1; m_fpend[0] = 1'b0; end
      else if (m_fpend[1]) begin en = 5'd2; m_fpend[1] = 1'b0; end
      else                 begin en = 5'd3; m_fpend[2] = 1'b0; end
    end else begin
      en = 5'd31; es = 64'(m_pend); tag = "R8 trouble"; trouble = 1'b1;
    end
    disp_expect(tag, en, es, ef);
  endtask

  task automatic drain();
    bit tr;
    for (int k = 0; k < 8; k++) begin
      disp_model(tr);
      chk("R7 pend_any after dispatch", 64'(pend_any),
          64'((m_pend != 0) || (compat_mode && m_fpend != 0)));
      if (tr) break;
    end
  endtask

  function automatic logic [63:0] sub_of(int n, int s);
    return {8'hC3, 8'(s), 8'(n), 8'h5A, 32'(n * 32'h01010101) ^ 32'(s * 977)};
  endfunction

  initial begin
    compat_mode = 1'b0; allow_timer = 1'b0;
    do_reset();
    chk("R1 valid", 64'(fault_valid), 64'd0);
    chk("R1 pend_any", 64'(pend_any), 64'd0);
    chk("R1 pend_no_timer", 64'(pend_no_timer), 64'd0);
    disp_expect("R1 empty trouble", 5'd31, 64'd0, 1'b0);

    // sweep: pending subsets over bits {0,4,8,15}, allow, compat, floating mask
    for (int s = 0; s < 16; s++) begin
      for (int al = 0; al < 2; al++) begin
        for (int cp = 0; cp < 2; cp++) begin
          for (int fm = 0; fm < 8; fm++) begin
            int bits [4];
            int sc;
            bits = '{0, 4, 8, 15};
            sc = s * 64 + al * 32 + cp * 16 + fm;
            allow_timer = al[0]; compat_mode = cp[0];
            do_reset();
            for (int j = 0; j < 4; j++) begin
              if (s[j]) begin
                set_req(bits[j], ~sub_of(bits[j], sc));
                set_req(bits[j], sub_of(bits[j], sc));
                m_pend[bits[j]] = 1'b1;
              end
            end
            for (int i = 0; i < 3; i++) begin
              if (fm[i]) begin
                set_float(2 * (i + 1));
                m_fstage[i] = 1'b1;
              end
            end
            chk("R2 staged not pending", 64'(pend_any), 64'd0);
            pulse_adv();
            if (compat_mode) begin m_fpend = m_fstage; m_fstage = '0; end
            chk("R9 pend_any", 64'(pend_any),
                64'((m_pend != 0) || (compat_mode && m_fpend != 0)));
            chk("R10 pend_no_timer", 64'(pend_no_timer),
                64'(((m_pend & ~32'h10) != 0) || (compat_mode && m_fpend != 0)));
            drain();
            if (!compat_mode && m_fstage != 0) begin
              compat_mode = 1'b1;
              chk("R4 held while compat off", 64'(pend_any), 64'(m_pend != 0));
              pulse_adv();
              m_fpend = m_fstage; m_fstage = '0;
              chk("R4 promoted with compat", 64'(pend_any), 64'd1);
              drain();
            end
          end
        end
      end
    end

    // timer clear removes only bit 4
    allow_timer = 1'b1; compat_mode = 1'b0;
    do_reset();
    set_req(4, 64'h44); set_req(8, 64'h88);
    pulse_adv();
    chk("R10 no_timer with conn", 64'(pend_no_timer), 64'd1);
    timer_clr = 1'b1; tick(); timer_clr = 1'b0;
    chk("R11 pend_any kept", 64'(pend_any), 64'd1);
    disp_expect("R11 conn left", 5'd8, 64'h88, 1'b0);
    chk("R11 nothing left", 64'(pend_any), 64'd0);
    disp_expect("R11 trouble empty", 5'd31, 64'd0, 1'b0);

    // only timer pending, timer not allowed
    allow_timer = 1'b0;
    do_reset();
    set_req(4, 64'h1234);
    pulse_adv();
    chk("R10 timer only any", 64'(pend_any), 64'd1);
    chk("R10 timer only no_timer", 64'(pend_no_timer), 64'd0);
    disp_expect("R5 timer skipped", 5'd31, 64'h10, 1'b0);
    allow_timer = 1'b1;
    disp_expect("R5 timer allowed", 5'd4, 64'h1234, 1'b0);

    // set request in the same cycle as advance stays staged
    do_reset();
    req_set = 1'b1; req_num = 5'd15; req_sub = 64'hE15; advance = 1'b1;
    tick();
    req_set = 1'b0; advance = 1'b0;
    chk("R3 same-cycle set staged", 64'(pend_any), 64'd0);
    pulse_adv();
    chk("R3 promoted next advance", 64'(pend_any), 64'd1);
    disp_expect("R3 exec", 5'd15, 64'hE15, 1'b0);

    // dispatch together with advance: re-staged bit survives, newest subcode used
    do_reset();
    set_req(8, 64'hA);
    pulse_adv();
    set_req(8, 64'hB);
    advance = 1'b1;
    disp_expect("R13 dispatch with advance", 5'd8, 64'hB, 1'b0);
    advance = 1'b0;
    chk("R13 promoted bit kept", 64'(pend_any), 64'd1);
    disp_expect("R13 second conn", 5'd8, 64'hB, 1'b0);

    // timer clear together with promotion of timer bit
    do_reset();
    set_req(4, 64'h7);
    timer_clr = 1'b1; advance = 1'b1;
    tick();
    timer_clr = 1'b0; advance = 1'b0;
    chk("R13 clear then promote any", 64'(pend_any), 64'd1);
    chk("R13 clear then promote no_timer", 64'(pend_no_timer), 64'd0);

    // floating code decode: 0 and 1 ignored, 7 maps to bit 2
    compat_mode = 1'b1;
    do_reset();
    set_float(0); set_float(1);
    pulse_adv();
    chk("R4 low codes ignored", 64'(pend_any), 64'd0);
    set_float(7);
    pulse_adv();
    chk("R4 code 7 pending", 64'(pend_any), 64'd1);
    disp_expect("R6 code 7 as float 3", 5'd3, 64'd0, 1'b1);
    compat_mode = 1'b0;
    set_float(3);
    pulse_adv();
    chk("R9 float ignored in status", 64'(pend_any), 64'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule